// File: doc/BRIEF.md
# Multi-Page-Size Translation Probe Sequencer

This block sequences a single translation lookup across the four page-size classes of one realm (data or instruction). Each realm keeps an 8-bit coverage register. The register records, for every size class, whether process-local entries or global entries have ever been inserted there. A lookup request captures the coverage of its realm. The block then visits the populated classes one per cycle, largest page first, and presents a probe (virtual page number, size class, realm, address-space number) to an external translation array. The array answers in the same cycle. The walk ends at the first hit and returns the frame number, the permission mask and the size class that hit. If no probe hits, the block returns a miss. When the requester already knows the page size, only that one class is probed.

On the fill side, every insert passes through a page-size check. The virtual address and the frame number must both be aligned to the claimed page size. If either one is not, the insert is demoted to the 8 KB base class. The checked class goes to the array and sets one coverage bit. Coverage bits are only ever set by inserts and only ever cleared by a full flush of a realm. A coverage bit can therefore be stale, but a populated class is never skipped.

Requests use a valid/ready handshake. `req_ready` is high only while no lookup is in flight. A request is taken on the edge where `req_valid` and `req_ready` are both high. The response is held stable, `rsp_valid` included, until `rsp_ready` is seen high at a clock edge. No new request is taken before that edge. Fills and flushes are plain strobes and are always taken.

Top module: `xlat_probe_seq`

## Requirements
- R1: Size class g (2-bit code: 0 = 8 KB, 1 = 64 KB, 2 = 512 KB, 3 = 4 MB) uses page shift 13+3g. A probe of class g carries `probe_vpn` = VA >> (13+3g).
- R2: A fill sets coverage bit {global, checked class} of its realm, where bit index = 4×global + class. Bits 3:0 are the process-local classes and bits 7:4 are the global classes. The change is visible on `cov_data` (realm 0) or `cov_inst` (realm 1) after the next clock edge.
- R3: A flush zeroes the coverage of each realm whose bit is set in `flush_realms` (bit 0 = data, bit 1 = instruction), and leaves the other realm unchanged. Coverage is never cleared any other way. A fill in the same cycle as a flush of the same realm leaves only the fill's bit set.
- R4: With `req_gh_known` = 0, the block probes, one per cycle and largest first, exactly the classes whose global or process-local coverage bit was set when the request was taken. Classes with both bits clear are not probed.
- R5: With `req_gh_known` = 1, the block probes only class `req_gh`, whatever the coverage.
- R6: The walk stops at the first probe with `probe_hit` = 1. The response then has `rsp_hit` = 1, with that probe's `probe_pfn`, `probe_perm` and class.
- R7: A miss (`rsp_hit` = 0, `rsp_gh` = 0) is given after the last selected class has been probed. `rsp_valid` rises k cycles after the accepting edge, where k is the number of probes (zero probes gives the cycle right after acceptance).
- R8: On a fill of class g > 0, if VA bits [12+3g:13] or PFN bits [3g-1:0] are not all zero, `ins_gh` is 0. Otherwise `ins_gh` equals `fill_gh`. `ins_gh` is never above `fill_gh`.
- R9: `req_ready` is high only when idle. A response waiting on `rsp_ready` keeps `rsp_valid` and all its fields stable.
- R10: After reset, both coverage registers are zero, `req_ready` = 1, and `rsp_valid` = 0 and `probe_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_va | input | VA_W | Virtual address to translate |
| req_asn | input | ASN_W | Address-space number, forwarded with each probe |
| req_realm | input | 1 | 0 = data, 1 = instruction |
| req_gh_known | input | 1 | Page size supplied with the request |
| req_gh | input | 2 | Supplied size class |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_hit | output | 1 | Translation found |
| rsp_pfn | output | PFN_W | Frame number of the hit |
| rsp_perm | output | 4 | Permission mask of the hit |
| rsp_gh | output | 2 | Size class of the hit (0 on miss) |
| probe_valid | output | 1 | Probe issued this cycle |
| probe_realm | output | 1 | Realm of the probe |
| probe_asn | output | ASN_W | Address-space number of the probe |
| probe_vpn | output | VA_W-13 | Page number for the probed class |
| probe_gh | output | 2 | Probed size class |
| probe_hit | input | 1 | Array reports a live match (same cycle) |
| probe_pfn | input | PFN_W | Frame number from the array |
| probe_perm | input | 4 | Permission mask from the array |
| fill_valid | input | 1 | Insert strobe |
| fill_realm | input | 1 | Realm of the insert |
| fill_global | input | 1 | Insert is global to all address spaces |
| fill_va | input | VA_W | Virtual address of the insert |
| fill_pfn | input | PFN_W | Frame number of the insert |
| fill_gh | input | 2 | Claimed size class |
| ins_gh | output | 2 | Checked size class for the array |
| flush_valid | input | 1 | Full flush strobe |
| flush_realms | input | 2 | Realms to flush (bit 0 data, bit 1 instruction) |
| cov_data | output | 8 | Coverage register, data realm |
| cov_inst | output | 8 | Coverage register, instruction realm |

## Verification
The bench builds the block with its default parameters: VA_W = 43, PFN_W = 31 and ASN_W = 8. With these values the 4 MB class keeps a 21-bit page number, and the widest alignment window (nine VA bits above the offset and nine frame bits) lies fully inside both fields. Demotion on a misaligned address and demotion on a misaligned frame can therefore both be driven. The array's response is modelled by a table of inserted entries, keyed on realm, checked class and page number. With this model, walks that hit on the first probe, hit after a skipped class, or miss after every populated class all appear with known probe counts and orders.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int NUM_CLS    = 4;
  localparam int NUM_REALMS = 2;
  localparam int GH_W       = 2;
  localparam int COV_W      = 2 * NUM_CLS;
  localparam int COV_IDX_W  = $clog2(COV_W);
  localparam int BASE_SHIFT = 13;
  localparam int GH_STEP    = 3;
  localparam int PERM_W     = 4;

  typedef enum logic [1:0] {
    WALK_IDLE,
    WALK_PROBE,
    WALK_RESP
  } walk_st_e;

  // highest set class in a pending mask (0 when empty)
  function automatic logic [GH_W-1:0] top_class(input logic [NUM_CLS-1:0] m);
    logic [GH_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CLS; i++) begin
      if (m[i]) r = GH_W'(i);
    end
    return r;
  endfunction

  function automatic int page_shift(input logic [GH_W-1:0] gh);
    return BASE_SHIFT + GH_STEP * int'(gh);
  endfunction
endpackage

// File: rtl/xlat_cov_bank.sv
module xlat_cov_bank
  import xlat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 set_en,
  input  logic [COV_IDX_W-1:0] set_idx,
  output logic [COV_W-1:0]     cov
);
  logic [COV_W-1:0] cov_n;

  // clear applies first, a same-cycle insert lands on top of it
  always_comb begin
    cov_n = clr ? '0 : cov;
    if (set_en) cov_n[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cov <= '0;
    else        cov <= cov_n;
  end
endmodule

// File: rtl/xlat_fill_check.sv
module xlat_fill_check
  import xlat_pkg::*;
#(
  parameter int VA_W  = 43,
  parameter int PFN_W = 31
) (
  input  logic [VA_W-1:0]  fill_va,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [GH_W-1:0]  fill_gh,
  output logic [GH_W-1:0]  ok_gh
);
  localparam int MAX_LOW = GH_STEP * (NUM_CLS - 1);

  logic misal;
  logic unused_bits;

  always_comb begin
    misal = 1'b0;
    for (int i = 0; i < MAX_LOW; i++) begin
      if (i < GH_STEP * int'(fill_gh))
        misal = misal | fill_va[BASE_SHIFT+i] | fill_pfn[i];
    end
  end

  // demotion only ever lowers the class
  assign ok_gh = misal ? '0 : fill_gh;

  assign unused_bits = ^{fill_va[BASE_SHIFT-1:0], fill_va[VA_W-1:BASE_SHIFT+MAX_LOW],
                         fill_pfn[PFN_W-1:MAX_LOW]};
endmodule

// File: rtl/xlat_probe_walker.sv
module xlat_probe_walker
  import xlat_pkg::*;
#(
  parameter int VA_W  = 43,
  parameter int PFN_W = 31,
  parameter int ASN_W = 8,
  localparam int VPN_W = VA_W - BASE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASN_W-1:0]  req_asn,
  input  logic              req_realm,
  input  logic              req_gh_known,
  input  logic [GH_W-1:0]   req_gh,
  input  logic [COV_W-1:0]  req_cov,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [PERM_W-1:0] rsp_perm,
  output logic [GH_W-1:0]   rsp_gh,
  output logic              probe_valid,
  output logic              probe_realm,
  output logic [ASN_W-1:0]  probe_asn,
  output logic [VPN_W-1:0]  probe_vpn,
  output logic [GH_W-1:0]   probe_gh,
  input  logic              probe_hit,
  input  logic [PFN_W-1:0]  probe_pfn,
  input  logic [PERM_W-1:0] probe_perm
);
  walk_st_e             st_q;
  logic [VA_W-1:0]      va_q;
  logic [ASN_W-1:0]     asn_q;
  logic                 realm_q;
  logic [NUM_CLS-1:0]   pend_q;
  logic                 hit_q;
  logic [PFN_W-1:0]     pfn_q;
  logic [PERM_W-1:0]    perm_q;
  logic [GH_W-1:0]      gh_q;

  logic [NUM_CLS-1:0]   start_mask;
  logic [NUM_CLS-1:0]   pend_left;
  logic [GH_W-1:0]      cur_gh;

  // classes to visit: the supplied one, or every populated one
  always_comb begin
    start_mask = '0;
    if (req_gh_known) begin
      start_mask[req_gh] = 1'b1;
    end else begin
      for (int g = 0; g < NUM_CLS; g++)
        start_mask[g] = req_cov[g] | req_cov[g+NUM_CLS];
    end
  end

  assign cur_gh    = top_class(pend_q);
  assign pend_left = pend_q & ~(NUM_CLS'(1) << cur_gh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= WALK_IDLE;
      va_q    <= '0;
      asn_q   <= '0;
      realm_q <= 1'b0;
      pend_q  <= '0;
      hit_q   <= 1'b0;
      pfn_q   <= '0;
      perm_q  <= '0;
      gh_q    <= '0;
    end else begin
      case (st_q)
        WALK_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            asn_q   <= req_asn;
            realm_q <= req_realm;
            pend_q  <= start_mask;
            hit_q   <= 1'b0;
            pfn_q   <= '0;
            perm_q  <= '0;
            gh_q    <= '0;
            st_q    <= (start_mask == '0) ? WALK_RESP : WALK_PROBE;
          end
        end
        WALK_PROBE: begin
          if (probe_hit) begin
            hit_q  <= 1'b1;
            pfn_q  <= probe_pfn;
            perm_q <= probe_perm;
            gh_q   <= cur_gh;
            pend_q <= '0;
            st_q   <= WALK_RESP;
          end else begin
            pend_q <= pend_left;
            if (pend_left == '0) st_q <= WALK_RESP;
          end
        end
        WALK_RESP: begin
          if (rsp_ready) st_q <= WALK_IDLE;
        end
        default: st_q <= WALK_IDLE;
      endcase
    end
  end

  assign req_ready   = (st_q == WALK_IDLE);
  assign rsp_valid   = (st_q == WALK_RESP);
  assign rsp_hit     = hit_q;
  assign rsp_pfn     = pfn_q;
  assign rsp_perm    = perm_q;
  assign rsp_gh      = gh_q;
  assign probe_valid = (st_q == WALK_PROBE);
  assign probe_realm = realm_q;
  assign probe_asn   = asn_q;
  assign probe_gh    = cur_gh;
  assign probe_vpn   = VPN_W'(va_q >> page_shift(cur_gh));
endmodule

// File: rtl/xlat_probe_seq.sv
module xlat_probe_seq
  import xlat_pkg::*;
#(
  parameter int VA_W  = 43,
  parameter int PFN_W = 31,
  parameter int ASN_W = 8,
  localparam int VPN_W = VA_W - BASE_SHIFT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_va,
  input  logic [ASN_W-1:0]      req_asn,
  input  logic                  req_realm,
  input  logic                  req_gh_known,
  input  logic [1:0]            req_gh,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_hit,
  output logic [PFN_W-1:0]      rsp_pfn,
  output logic [3:0]            rsp_perm,
  output logic [1:0]            rsp_gh,
  output logic                  probe_valid,
  output logic                  probe_realm,
  output logic [ASN_W-1:0]      probe_asn,
  output logic [VPN_W-1:0]      probe_vpn,
  output logic [1:0]            probe_gh,
  input  logic                  probe_hit,
  input  logic [PFN_W-1:0]      probe_pfn,
  input  logic [3:0]            probe_perm,
  input  logic                  fill_valid,
  input  logic                  fill_realm,
  input  logic                  fill_global,
  input  logic [VA_W-1:0]       fill_va,
  input  logic [PFN_W-1:0]      fill_pfn,
  input  logic [1:0]            fill_gh,
  output logic [1:0]            ins_gh,
  input  logic                  flush_valid,
  input  logic [1:0]            flush_realms,
  output logic [7:0]            cov_data,
  output logic [7:0]            cov_inst
);
  logic [COV_W-1:0] cov_q [NUM_REALMS];
  logic [COV_W-1:0] req_cov;

  xlat_fill_check #(.VA_W(VA_W), .PFN_W(PFN_W)) u_fchk (
    .fill_va  (fill_va),
    .fill_pfn (fill_pfn),
    .fill_gh  (fill_gh),
    .ok_gh    (ins_gh)
  );

  for (genvar r = 0; r < NUM_REALMS; r++) begin : g_bank
    xlat_cov_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (flush_valid && flush_realms[r]),
      .set_en  (fill_valid && (fill_realm == 1'(r))),
      .set_idx ({fill_global, ins_gh}),
      .cov     (cov_q[r])
    );
  end

  assign req_cov  = cov_q[req_realm];
  assign cov_data = cov_q[0];
  assign cov_inst = cov_q[1];

  xlat_probe_walker #(.VA_W(VA_W), .PFN_W(PFN_W), .ASN_W(ASN_W)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_va       (req_va),
    .req_asn      (req_asn),
    .req_realm    (req_realm),
    .req_gh_known (req_gh_known),
    .req_gh       (req_gh),
    .req_cov      (req_cov),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_hit      (rsp_hit),
    .rsp_pfn      (rsp_pfn),
    .rsp_perm     (rsp_perm),
    .rsp_gh       (rsp_gh),
    .probe_valid  (probe_valid),
    .probe_realm  (probe_realm),
    .probe_asn    (probe_asn),
    .probe_vpn    (probe_vpn),
    .probe_gh     (probe_gh),
    .probe_hit    (probe_hit),
    .probe_pfn    (probe_pfn),
    .probe_perm   (probe_perm)
  );
endmodule

// File: rtl/xlat_probe_seq_chk.sv
module xlat_probe_seq_chk #(
  parameter int PFN_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic [3:0]       rsp_perm,
  input logic [1:0]       rsp_gh,
  input logic             probe_valid,
  input logic             probe_hit,
  input logic [1:0]       probe_gh,
  input logic [PFN_W-1:0] probe_pfn,
  input logic             fill_valid,
  input logic             fill_realm,
  input logic [1:0]       fill_gh,
  input logic [1:0]       ins_gh,
  input logic             flush_valid,
  input logic [1:0]       flush_realms,
  input logic [7:0]       cov_data,
  input logic [7:0]       cov_inst
);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_pfn)
                                && $stable(rsp_perm) && $stable(rsp_gh));

  // R9
  busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || probe_valid) |-> !req_ready);

  // R4
  probe_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid && !probe_hit |=> !probe_valid || (probe_gh < $past(probe_gh)));

  // R6
  hit_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid && probe_hit |=> rsp_valid && rsp_hit && (rsp_gh == $past(probe_gh))
                                 && (rsp_pfn == $past(probe_pfn)));

  // R3
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && flush_realms[0] && !(fill_valid && !fill_realm) |=> cov_data == 8'h00);

  // R3
  cov_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_valid |=> ((cov_data & $past(cov_data)) == $past(cov_data))
                     && ((cov_inst & $past(cov_inst)) == $past(cov_inst)));

  // R8
  demote_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> ins_gh <= fill_gh);
endmodule

bind xlat_probe_seq xlat_probe_seq_chk #(.PFN_W(PFN_W)) chk_i (.*);

// File: tb/xlat_probe_seq_tb_top.sv
`timescale 1ns/1ps
module xlat_probe_seq_tb_top;
  localparam int VA_W  = 43;
  localparam int PFN_W = 31;
  localparam int ASN_W = 8;
  localparam int VPN_W = VA_W - 13;
  localparam int MAX_ENT = 8;
  localparam int NVEC = 9;

  // {realm, known, gh, va[31:0], exp_hit, exp_gh, exp_np[2:0], exp_first, exp_pfn[15:0], exp_perm}
  localparam logic [63:0] VEC [NVEC] = '{
    {1'b0,1'b0,2'd0,32'h0000A000,1'b1,2'd0,3'd2,2'd2,16'h0111,4'h3},
    {1'b0,1'b0,2'd0,32'h00181234,1'b1,2'd2,3'd1,2'd2,16'h0080,4'hC},
    {1'b0,1'b0,2'd0,32'h00012000,1'b1,2'd0,3'd2,2'd2,16'h0200,4'h6},
    {1'b0,1'b0,2'd0,32'h00040000,1'b0,2'd0,3'd2,2'd2,16'h0000,4'h0},
    {1'b1,1'b0,2'd0,32'h00800005,1'b1,2'd3,3'd1,2'd3,16'h0400,4'h5},
    {1'b1,1'b0,2'd0,32'h00C00000,1'b1,2'd0,3'd2,2'd3,16'h0401,4'h9},
    {1'b0,1'b1,2'd1,32'h00012000,1'b0,2'd0,3'd1,2'd1,16'h0000,4'h0},
    {1'b0,1'b1,2'd0,32'h0000A000,1'b1,2'd0,3'd1,2'd0,16'h0111,4'h3},
    {1'b1,1'b0,2'd0,32'h00002000,1'b0,2'd0,3'd2,2'd3,16'h0000,4'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_realm = 1'b0, req_gh_known = 1'b0;
  logic [VA_W-1:0] req_va = '0;
  logic [ASN_W-1:0] req_asn = 8'h05;
  logic [1:0] req_gh = 2'd0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_hit;
  logic [PFN_W-1:0] rsp_pfn;
  logic [3:0] rsp_perm;
  logic [1:0] rsp_gh;
  logic probe_valid, probe_realm, probe_hit;
  logic [ASN_W-1:0] probe_asn;
  logic [VPN_W-1:0] probe_vpn;
  logic [1:0] probe_gh;
  logic [PFN_W-1:0] probe_pfn;
  logic [3:0] probe_perm;
  logic fill_valid = 1'b0, fill_realm = 1'b0, fill_global = 1'b0;
  logic [VA_W-1:0] fill_va = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic [1:0] fill_gh = 2'd0, ins_gh;
  logic flush_valid = 1'b0;
  logic [1:0] flush_realms = 2'b00;
  logic [7:0] cov_data, cov_inst;

  int checks = 0, errors = 0;
  int n_probe = 0;
  logic [1:0] first_gh;
  logic [VPN_W-1:0] first_vpn;

  logic             ent_realm [MAX_ENT];
  logic [1:0]       ent_gh    [MAX_ENT];
  logic [VPN_W-1:0] ent_vpn   [MAX_ENT];
  logic [PFN_W-1:0] ent_pfn   [MAX_ENT];
  logic [3:0]       ent_perm  [MAX_ENT];
  int n_ent = 0;

  always #2 clk = ~clk;

  xlat_probe_seq #(.VA_W(VA_W), .PFN_W(PFN_W), .ASN_W(ASN_W)) dut_i (.*);

  // translation array stand-in: same-cycle answer
  always_comb begin
    probe_hit  = 1'b0;
    probe_pfn  = '0;
    probe_perm = '0;
    for (int i = 0; i < MAX_ENT; i++) begin
      if (i < n_ent && ent_realm[i] == probe_realm && ent_gh[i] == probe_gh
          && ent_vpn[i] == probe_vpn) begin
        probe_hit  = 1'b1;
        probe_pfn  = ent_pfn[i];
        probe_perm = ent_perm[i];
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && probe_valid) begin
      if (n_probe == 0) begin
        first_gh  = probe_gh;
        first_vpn = probe_vpn;
      end
      n_probe = n_probe + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic realm, input logic glob, input logic [VA_W-1:0] va,
                         input logic [PFN_W-1:0] pfn, input logic [3:0] perm,
                         input logic [1:0] gh, input logic [1:0] exp_gh, input logic [7:0] exp_cov);
    @(negedge clk);
    fill_valid = 1'b1; fill_realm = realm; fill_global = glob;
    fill_va = va; fill_pfn = pfn; fill_gh = gh;
    #1;
    chk(ins_gh == exp_gh, "R8 checked class", 64'(ins_gh), 64'(exp_gh));
    ent_realm[n_ent] = realm;
    ent_gh[n_ent]    = exp_gh;
    ent_vpn[n_ent]   = VPN_W'(va >> (13 + 3 * int'(exp_gh)));
    ent_pfn[n_ent]   = pfn;
    ent_perm[n_ent]  = perm;
    n_ent++;
    @(negedge clk);
    fill_valid = 1'b0;
    if (realm) chk(cov_inst == exp_cov, "R2 cov_inst", 64'(cov_inst), 64'(exp_cov));
    else       chk(cov_data == exp_cov, "R2 cov_data", 64'(cov_data), 64'(exp_cov));
  endtask

  task automatic do_lookup(input logic realm, input logic known, input logic [1:0] gh,
                           input logic [VA_W-1:0] va, input logic exp_hit, input logic [1:0] exp_gh,
                           input int exp_np, input logic [1:0] exp_first,
                           input logic [PFN_W-1:0] exp_pfn, input logic [3:0] exp_perm);
    int lat;
    logic [VPN_W-1:0] exp_vpn;
    @(negedge clk);
    n_probe = 0;
    req_valid = 1'b1; req_realm = realm; req_gh_known = known; req_gh = gh; req_va = va;
    rsp_ready = 1'b1;
    chk(req_ready == 1'b1, "R9 ready when idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(rsp_hit == exp_hit, "R6 hit flag", 64'(rsp_hit), 64'(exp_hit));
    chk(rsp_gh == exp_gh, "R6 class", 64'(rsp_gh), 64'(exp_gh));
    if (exp_hit) begin
      chk(rsp_pfn == exp_pfn, "R6 pfn", 64'(rsp_pfn), 64'(exp_pfn));
      chk(rsp_perm == exp_perm, "R6 perm", 64'(rsp_perm), 64'(exp_perm));
    end
    chk(lat == exp_np, "R7 latency", 64'(lat), 64'(exp_np));
    chk(n_probe == exp_np, "R4 probe count", 64'(n_probe), 64'(exp_np));
    if (exp_np > 0) begin
      exp_vpn = VPN_W'(va >> (13 + 3 * int'(exp_first)));
      chk(first_gh == exp_first, "R5 first class", 64'(first_gh), 64'(exp_first));
      chk(first_vpn == exp_vpn, "R1 probe vpn", 64'(first_vpn), 64'(exp_vpn));
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 response retired", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic hold_hit;
    logic [PFN_W-1:0] hold_pfn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(cov_data == 8'h00 && cov_inst == 8'h00, "R10 coverage", 64'({cov_data, cov_inst}), 64'd0);
    chk(req_ready == 1'b1, "R10 ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0 && probe_valid == 1'b0, "R10 idle outputs",
        64'({rsp_valid, probe_valid}), 64'd0);

    // R7 empty coverage: miss with no probe
    do_lookup(1'b0, 1'b0, 2'd0, 43'h0000A000, 1'b0, 2'd0, 0, 2'd0, '0, 4'h0);

    // fills (R2, R8)
    do_fill(1'b0, 1'b0, 43'h0000A000, 31'h111, 4'h3, 2'd0, 2'd0, 8'h01);
    do_fill(1'b0, 1'b1, 43'h00180000, 31'h080, 4'hC, 2'd2, 2'd2, 8'h41);
    do_fill(1'b0, 1'b1, 43'h00012000, 31'h200, 4'h6, 2'd1, 2'd0, 8'h51); // VA misaligned
    do_fill(1'b1, 1'b0, 43'h00800000, 31'h400, 4'h5, 2'd3, 2'd3, 8'h08);
    do_fill(1'b1, 1'b0, 43'h00C00000, 31'h401, 4'h9, 2'd3, 2'd0, 8'h09); // PFN misaligned

    // vector table: R1, R4, R5, R6, R7
    for (int k = 0; k < NVEC; k++) begin
      v = VEC[k];
      do_lookup(v[63], v[62], v[61:60], VA_W'(v[59:28]), v[27], v[26:25], int'(v[24:22]),
                v[21:20], PFN_W'(v[19:4]), v[3:0]);
    end

    // R9 back-pressure hold
    @(negedge clk);
    req_valid = 1'b1; req_realm = 1'b0; req_gh_known = 1'b0; req_va = 43'h00181234;
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    hold_hit = rsp_hit;
    hold_pfn = rsp_pfn;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_hit == hold_hit && rsp_pfn == hold_pfn && !req_ready,
          "R9 hold under back-pressure", 64'({rsp_valid, rsp_hit, req_ready}), 64'h6);
    end
    chk(hold_pfn == 31'h080, "R9 held pfn", 64'(hold_pfn), 64'h80);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 release", 64'({rsp_valid, req_ready}), 64'd1);

    // R3 flush of data realm only
    @(negedge clk);
    flush_valid = 1'b1; flush_realms = 2'b01;
    @(negedge clk);
    flush_valid = 1'b0;
    chk(cov_data == 8'h00, "R3 data flushed", 64'(cov_data), 64'd0);
    chk(cov_inst == 8'h09, "R3 inst kept", 64'(cov_inst), 64'h09);

    // R7 flushed realm: immediate miss, no probe
    do_lookup(1'b0, 1'b0, 2'd0, 43'h0000A000, 1'b0, 2'd0, 0, 2'd0, '0, 4'h0);

    // R3 flush and fill together: fill bit survives
    @(negedge clk);
    flush_valid = 1'b1; flush_realms = 2'b01;
    fill_valid = 1'b1; fill_realm = 1'b0; fill_global = 1'b1;
    fill_va = 43'h00004000; fill_pfn = 31'h33; fill_gh = 2'd0;
    @(negedge clk);
    flush_valid = 1'b0; fill_valid = 1'b0;
    chk(cov_data == 8'h10, "R3 flush with fill", 64'(cov_data), 64'h10);

    // R3 flush both realms
    @(negedge clk);
    flush_valid = 1'b1; flush_realms = 2'b11;
    @(negedge clk);
    flush_valid = 1'b0;
    chk(cov_data == 8'h00 && cov_inst == 8'h00, "R3 both flushed",
        64'({cov_data, cov_inst}), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule